// File: doc/BRIEF.md
# FPGA Configuration Load Controller

This block sits between a host register interface and a set of FPGAs that have to be configured at start-up: one system device and up to four filter devices. The host writes a 16-bit control word in which each target device owns one bit. Writing 1 to a target's bit marks that target as loading. The same write clears the target's byte count and starts a hold-off interval. Once the hold-off has expired, the host streams configuration bytes through one of two byte ports. One port feeds the system device. The other feeds every selected filter device at once with the same byte.

The block counts the bytes accepted by each target. A target's bit drops back to 0 only when its full bitstream has been delivered and the target reports done. A single read of the register therefore shows whether every download succeeded: the value is zero when they all did. In the two-device build, only two physical filter devices exist. Their two unused bits ignore writes and read back as copies of the bits of the devices that are present. Two further bits of the word are plain control outputs that drive trigger termination.

Top module: `cfg_load_ctrl`

## Requirements
- R1: After reset the register reads 0x0000, no byte strobe is active and both termination outputs are 0.
- R2: A register write with 1 in bit 0 (system) or in a present filter bit among bits 4..7 sets that bit, so it reads 1, and starts that target's load. A 0 written to a target bit leaves that bit unchanged.
- R3: A data byte written within HOLD_CYCLES cycles of the latest load start is dropped. HOLD_CYCLES defaults to 5,000,000, which is 50 ms at 100 MHz. After the hold-off, an accepted byte appears on the output one cycle after its write, with a strobe for each target that takes it.
- R4: A byte on the system port goes only to the system target (strobe bit 0). A byte on the filter port goes to every loading filter target in the same cycle (strobe bits 1..4 for register bits 4..7).
- R5: A target bit stays 1 until that target has accepted BITSTREAM_LEN bytes (default 166980) and its done input is high, and then reads 0. A done input that rises before the count is full has no effect.
- R6: Once a target has accepted BITSTREAM_LEN bytes, further bytes are not forwarded to it.
- R7: A data byte written while no target on that port is loading is dropped. No strobe is produced and no count changes.
- R8: With PAIRED=1, writes to bits 5 and 7 are ignored. Bit 5 reads as bit 4 and bit 7 reads as bit 6. Strobe bits 2 and 4 never assert.
- R9: With PAIRED=0, bits 5 and 7 are independent targets that load and read back like bits 4 and 6.
- R10: Every register write loads bits 10 and 13 into term_o[0] and term_o[1], and they read back in place. All bits other than 0, 4..7, 10 and 13 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 16 | Control word write data |
| reg_rdata_o | output | 16 | Control word read data |
| sys_wr_i | input | 1 | System port byte write |
| sys_byte_i | input | 8 | System port byte |
| filt_wr_i | input | 1 | Filter port byte write |
| filt_byte_i | input | 8 | Filter port byte |
| sys_cfg_byte_o | output | 8 | Byte forwarded to the system target |
| filt_cfg_byte_o | output | 8 | Byte forwarded to the filter targets |
| cfg_wr_o | output | 5 | Per-target byte strobe (0 system, 1..4 filters) |
| cfg_done_i | input | 5 | Per-target configuration done |
| term_o | output | 2 | Trigger termination controls |

## Verification
A control write is visible on reg_rdata_o straight after the edge that takes it. Both the register and term_o are sampled at the following falling edge. A forwarded byte carries one register stage, so a scoreboard queue receives the expected byte and strobe mask when the bench drives the write. The monitor then pops and compares that entry at the falling edge after the next rising edge. Dropped bytes are checked at that same falling edge for an all-zero strobe. A busy bit clears two edges after the final byte strobe: one edge for the target model to raise done and one for the block to clear the bit. The bench therefore waits four cycles before it reads the completion state, and it waits HOLD_CYCLES plus two cycles after each load start before it streams data.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;
  localparam int REG_W     = 16;
  localparam int N_SLOT    = 5;   // slot 0 system, slots 1..4 filters
  localparam int SYS_BIT   = 0;
  localparam int FILT_BASE = 4;   // register bit of slot 1
  localparam int TERM_LO   = 10;
  localparam int TERM_HI   = 13;

  function automatic int slot_bit(input int k);
    return (k == 0) ? SYS_BIT : FILT_BASE + k - 1;
  endfunction

  function automatic bit slot_present(input int k, input bit paired);
    return !(paired && (k == 2 || k == 4));
  endfunction
endpackage

// File: rtl/cfg_hold_timer.sv
module cfg_hold_timer #(
  parameter int HOLD_CYCLES = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o
);
  localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= HOLD_C;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);

  // R3
  hold_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && HOLD_CYCLES > 0) |=> !ready_o);
endmodule

// File: rtl/cfg_load_slot.sv
module cfg_load_slot #(
  parameter int BITSTREAM_LEN = 166980
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ready_i,
  input  logic byte_wr_i,
  input  logic done_i,
  output logic busy_o,
  output logic wr_o
);
  localparam int CW = $clog2(BITSTREAM_LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(BITSTREAM_LEN);

  logic [CW-1:0] cnt_q;
  logic          busy_q, wr_q;
  logic          full, take;

  assign full = (cnt_q == LEN_C);
  assign take = busy_q & ready_i & byte_wr_i & ~full & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      wr_q <= take;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        if (take) cnt_q <= cnt_q + 1'b1;
        if (busy_q && full && done_i) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign wr_o   = wr_q;

  // R6
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LEN_C);

  // R5
  clear_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(full && done_i));

  // R5
  early_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !full && done_i) |=> busy_q);

  // R7
  strobe_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> $past(busy_q && byte_wr_i));
endmodule

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl
  import cfg_load_pkg::*;
#(
  parameter int BITSTREAM_LEN = 166980,
  parameter int HOLD_CYCLES   = 5_000_000,
  parameter bit PAIRED        = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              sys_wr_i,
  input  logic [7:0]        sys_byte_i,
  input  logic              filt_wr_i,
  input  logic [7:0]        filt_byte_i,
  output logic [7:0]        sys_cfg_byte_o,
  output logic [7:0]        filt_cfg_byte_o,
  output logic [N_SLOT-1:0] cfg_wr_o,
  input  logic [N_SLOT-1:0] cfg_done_i,
  output logic [1:0]        term_o
);
  logic [N_SLOT-1:0] start, busy;
  logic              ready;
  logic [1:0]        term_q;
  logic [7:0]        sys_q, filt_q;

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    if (slot_present(k, PAIRED)) begin : g_on
      assign start[k] = reg_wr_i & reg_wdata_i[slot_bit(k)];
      cfg_load_slot #(.BITSTREAM_LEN(BITSTREAM_LEN)) u_slot (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start[k]),
        .ready_i   (ready),
        .byte_wr_i ((k == 0) ? sys_wr_i : filt_wr_i),
        .done_i    (cfg_done_i[k]),
        .busy_o    (busy[k]),
        .wr_o      (cfg_wr_o[k])
      );
    end else begin : g_off
      assign start[k]    = 1'b0;
      assign busy[k]     = 1'b0;
      assign cfg_wr_o[k] = 1'b0;
    end
  end

  cfg_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (|start),
    .ready_o (ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q <= '0;
      sys_q  <= '0;
      filt_q <= '0;
    end else begin
      if (reg_wr_i)  term_q <= {reg_wdata_i[TERM_HI], reg_wdata_i[TERM_LO]};
      if (sys_wr_i)  sys_q  <= sys_byte_i;
      if (filt_wr_i) filt_q <= filt_byte_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < N_SLOT; k++) reg_rdata_o[slot_bit(k)] = busy[k];
    if (PAIRED) begin
      reg_rdata_o[slot_bit(2)] = busy[1];
      reg_rdata_o[slot_bit(4)] = busy[3];
    end
    reg_rdata_o[TERM_LO] = term_q[0];
    reg_rdata_o[TERM_HI] = term_q[1];
  end

  assign term_o          = term_q;
  assign sys_cfg_byte_o  = sys_q;
  assign filt_cfg_byte_o = filt_q;

  // R3
  strobe_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cfg_wr_o) |-> $past(ready));

  // R8
  mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PAIRED |-> (reg_rdata_o[5] == reg_rdata_o[4] && reg_rdata_o[7] == reg_rdata_o[6]
                && cfg_wr_o[2] == 1'b0 && cfg_wr_o[4] == 1'b0));

  // R10
  term_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> term_o == $past({reg_wdata_i[TERM_HI], reg_wdata_i[TERM_LO]}));

  // R4
  sys_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o[0] |-> $past(sys_wr_i));
endmodule

// File: tb/cfg_load_ctrl_tb.sv
module cfg_load_ctrl_tb;
  localparam int LEN  = 12;
  localparam int HOLD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        sys_wr = 1'b0, filt_wr = 1'b0;
  logic [7:0]  sys_b = '0, filt_b = '0;
  logic [15:0] rdata, rdata_f;
  logic [7:0]  sys_o, filt_o, sys_of, filt_of;
  logic [4:0]  wr_o, wr_of, done;
  logic [1:0]  term, term_f;
  logic [4:0]  force_done = '0, hold_done = '0;
  int          mcnt [5];
  int          errors = 0, checks = 0;
  logic [12:0] sb_q [$];

  always #5 clk = ~clk;

  cfg_load_ctrl #(.BITSTREAM_LEN(LEN), .HOLD_CYCLES(HOLD), .PAIRED(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sys_wr_i(sys_wr), .sys_byte_i(sys_b),
    .filt_wr_i(filt_wr), .filt_byte_i(filt_b), .sys_cfg_byte_o(sys_o),
    .filt_cfg_byte_o(filt_o), .cfg_wr_o(wr_o), .cfg_done_i(done), .term_o(term));

  cfg_load_ctrl #(.BITSTREAM_LEN(LEN), .HOLD_CYCLES(HOLD), .PAIRED(1'b0)) u_full (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_f), .sys_wr_i(sys_wr), .sys_byte_i(sys_b),
    .filt_wr_i(filt_wr), .filt_byte_i(filt_b), .sys_cfg_byte_o(sys_of),
    .filt_cfg_byte_o(filt_of), .cfg_wr_o(wr_of), .cfg_done_i(5'b0), .term_o(term_f));

  // behavioural targets: done once LEN bytes seen
  always @(posedge clk) begin
    for (int k = 0; k < 5; k++) begin
      int b;
      b = (k == 0) ? 0 : k + 3;
      if (reg_wr && wdata[b]) mcnt[k] <= 0;
      else if (wr_o[k])       mcnt[k] <= mcnt[k] + 1;
    end
  end
  always_comb
    for (int k = 0; k < 5; k++)
      done[k] = ((mcnt[k] >= LEN) && !hold_done[k]) || force_done[k];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_o != '0) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R7: actual=%0h expected=0 (unexpected strobe)", wr_o);
      end else begin
        logic [12:0] e;
        logic [7:0]  got;
        e   = sb_q.pop_front();
        got = wr_o[0] ? sys_o : filt_o;
        if (wr_o !== e[12:8] || got !== e[7:0]) begin
          errors++;
          $display("FAIL R4: actual=%0h expected=%0h", {wr_o, got}, e);
        end
      end
    end
  end

  task automatic wr_reg(input logic [15:0] d);
    @(posedge clk); #1 reg_wr = 1'b1; wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0; wdata = '0;
  endtask

  task automatic send(input bit filt, input logic [7:0] b, input logic [4:0] mask);
    if (mask != '0) sb_q.push_back({mask, b});
    @(posedge clk); #1
    if (filt) begin filt_wr = 1'b1; filt_b = b; end
    else      begin sys_wr  = 1'b1; sys_b  = b; end
    @(posedge clk); #1 filt_wr = 1'b0; sys_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 5; k++) mcnt[k] = 0;
    idle(3); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", rdata, 16'h0000);
    chk("R1 strobe", wr_o, 5'b0);
    chk("R1 term", term, 2'b00);

    // system load
    wr_reg(16'h0001);
    @(negedge clk); chk("R2 sys bit set", rdata, 16'h0001);
    send(1'b0, 8'h5A, 5'b0);                       // inside hold-off
    @(negedge clk); chk("R3 hold-off drop", wr_o, 5'b0);
    idle(HOLD + 2);
    for (int i = 0; i < LEN - 1; i++) send(1'b0, 8'(8'h10 + i), 5'b00001);
    idle(3);
    @(negedge clk); chk("R5 busy before full", rdata, 16'h0001);
    send(1'b0, 8'hEE, 5'b00001);
    idle(4);
    @(negedge clk); chk("R5 sys loaded", rdata, 16'h0000);

    // nothing loading on either port
    send(1'b0, 8'h33, 5'b0);
    @(negedge clk); chk("R7 idle sys drop", wr_o, 5'b0);
    send(1'b1, 8'h44, 5'b0);
    @(negedge clk); chk("R7 idle filt drop", wr_o, 5'b0);

    // bits 5 and 7 only
    wr_reg(16'h00A0);
    @(negedge clk); chk("R8 write ignored", rdata, 16'h0000);
    chk("R9 full variant bits", rdata_f, 16'h00A1);
    idle(HOLD + 2);
    send(1'b1, 8'h77, 5'b0);
    @(negedge clk); chk("R8 no strobe", wr_o, 5'b0);
    chk("R9 full variant strobe", wr_of, 5'b10100);
    chk("R2 zero write keeps sys bit", rdata_f[0], 1'b1);

    // filter pair, early done on slot 1, over-length on slot 3
    force_done[1] = 1'b1; hold_done[3] = 1'b1;
    wr_reg(16'h00F0);
    @(negedge clk); chk("R8 mirror read", rdata, 16'h00F0);
    idle(HOLD + 2);
    for (int i = 0; i < LEN - 1; i++) send(1'b1, 8'(8'hA0 + i), 5'b01010);
    idle(3);
    @(negedge clk); chk("R5 early done ignored", rdata, 16'h00F0);
    send(1'b1, 8'hC3, 5'b01010);
    force_done[1] = 1'b0;
    idle(4);
    @(negedge clk); chk("R5 slot1 done, slot3 waiting", rdata, 16'h00C0);
    send(1'b1, 8'hD1, 5'b0);
    @(negedge clk); chk("R6 over-length drop", wr_o, 5'b0);
    hold_done[3] = 1'b0;
    idle(4);
    @(negedge clk); chk("R5 all loaded", rdata, 16'h0000);

    // termination bits
    wr_reg(16'h2400);
    @(negedge clk); chk("R10 term read", rdata, 16'h2400);
    chk("R10 term out", term, 2'b11);
    wr_reg(16'hDB0F);
    @(negedge clk); chk("R10 masked bits", rdata & 16'hFB0E, 16'h0000);
    chk("R10 term cleared", term, 2'b00);
    idle(HOLD + LEN + 4);
    chk("R1 scoreboard drained", sb_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule